// File: doc/BRIEF.md
# Pin-Switched Reference Preselector

This block keeps two candidate clock-reference choices packed into one 8-bit configuration register. It is meant for the hard-wired manual selection mode of a timing controller. An external switch pin chooses which of the two choices is active. The active 4-bit code is decoded into a one-hot request vector with one bit each for free-run, references 1 to 5 and holdover. A downstream selector consumes that vector.

Software loads the register through a simple write port. A write is accepted only while the manual-mode enable bit from the mode-control register is high; at any other time the register keeps its contents. The switch pin is asynchronous to the block clock, so it passes through a two-flop synchronizer before it steers the field multiplexer. If the active field holds a code that selects nothing, a reserved-code flag is raised and the last valid request stays in force, so the reference never moves to an undefined choice.

Top module: `presel_top`

## Requirements
- R1: After reset the register reads 0x00, the request vector is free-run only (bit 0 set) and the reserved flag is 0.
- R2: A write with `manual_mode_en` high stores `cfg_wdata`, and `cfg_rdata` shows it after the next clock edge.
- R3: A write with `manual_mode_en` low leaves the register unchanged, and neither `cfg_rdata` nor `sel_req` changes.
- R4: While the synchronized switch is low, the low nibble (bits 3..0) is the active code; while it is high, the high nibble (bits 7..4) is the active code.
- R5: After the switch pin changes, `sel_req` keeps its old value for two clock edges and shows the new field's decode after the third edge.
- R6: Code 0 sets `sel_req` bit 0 (free-run), codes 1 to 5 set bit 1 to bit 5 (reference n), and code 13 sets bit 6 (holdover). The decode appears one clock edge after the register or the synchronized pin changes.
- R7: Codes 6 to 12, 14 and 15 set `sel_reserved` and leave `sel_req` at its previous value. A valid code clears the flag.
- R8: `sel_req` always has exactly one bit set.
- R9: `cfg_rdata` returns both fields whatever the state of `manual_mode_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Write data: choice A in bits 3..0, choice B in bits 7..4 |
| manual_mode_en | input | 1 | Write gate taken from the mode-control register |
| src_sw | input | 1 | Asynchronous switch pin: 0 picks choice A, 1 picks choice B |
| cfg_rdata | output | 8 | Current register contents |
| sel_req | output | 7 | One-hot request: bit 0 free-run, bits 1..5 references, bit 6 holdover |
| sel_reserved | output | 1 | The active code is not a defined selection |

## Verification
The hardest case to reach is a reserved code that must hold the previous selection. A reserved code has no output of its own, so a hold and a wrong decode look alike unless a known valid request comes just before. The stimulus therefore sweeps all sixteen codes in order through the high nibble. Each reserved code then follows a distinct valid request such as reference 5 or holdover. The pin is also toggled while the newly active field holds a different code, which checks the two-edge synchronizer delay and shows that the flag clears.

// File: rtl/presel_pkg.sv
package presel_pkg;
  localparam int FIELD_W     = 4;
  localparam int NUM_REFS    = 5;
  localparam int HOLD_CODE   = 13;
  localparam int SYNC_STAGES = 2;
  localparam int REG_W       = 2 * FIELD_W;
  localparam int SEL_W       = NUM_REFS + 2;
  localparam int FREERUN_BIT = 0;
  localparam int HOLD_BIT    = SEL_W - 1;

  typedef enum logic {
    FIELD_A = 1'b0,
    FIELD_B = 1'b1
  } field_pick_e;
endpackage

// File: rtl/presel_rst_sync.sv
module presel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/presel_pin_sync.sv
module presel_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign pin_o = sync_q[STAGES-1];
endmodule

// File: rtl/presel_reg.sv
module presel_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         gate_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic         load_en;
  logic [W-1:0] reg_q;
  logic [W-1:0] reg_d;

  always_comb begin
    load_en = wr_i & gate_i;
    reg_d   = load_en ? data_i : reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign q_o = reg_q;

  // R2: a gated-in write lands on the next edge
  assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && gate_i) |=> (q_o == $past(data_i)));

  // R3: without the gate the contents do not move
  assert_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && gate_i) |=> $stable(q_o));
endmodule

// File: rtl/presel_decode.sv
module presel_decode
  import presel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] code_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic               rsvd_o
);
  logic [SEL_W-1:0] match;
  logic             code_ok;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             rsvd_q;
  logic             rsvd_d;

  assign match[FREERUN_BIT] = (code_i == '0);
  assign match[HOLD_BIT]    = (code_i == FIELD_W'(HOLD_CODE));

  for (genvar g = 1; g <= NUM_REFS; g++) begin : g_ref_match
    assign match[g] = (code_i == FIELD_W'(g));
  end

  always_comb begin
    code_ok = |match;
    sel_d   = code_ok ? match : sel_q;
    rsvd_d  = ~code_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_W'(1) << FREERUN_BIT;
      rsvd_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      rsvd_q <= rsvd_d;
    end
  end

  assign sel_o  = sel_q;
  assign rsvd_o = rsvd_q;

  // R8: exactly one request at every edge
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel_o) == 1));

  // R7: a reserved code keeps the earlier request
  assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_o |-> $stable(sel_o));

  // R6: holdover code leads to the holdover request
  assert_hold_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == FIELD_W'(HOLD_CODE)) |=> (sel_o[HOLD_BIT] && !rsvd_o));

  // R6: code zero leads to free-run
  assert_freerun_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == '0) |=> (sel_o[FREERUN_BIT] && !rsvd_o));
endmodule

// File: rtl/presel_top.sv
module presel_top
  import presel_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             manual_mode_en,
  input  logic             src_sw,
  output logic [REG_W-1:0] cfg_rdata,
  output logic [SEL_W-1:0] sel_req,
  output logic             sel_reserved
);
  logic               rst_n;
  logic               sw_sync;
  logic [REG_W-1:0]   reg_q;
  logic [FIELD_W-1:0] active_code;
  field_pick_e        pick;

  presel_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  presel_pin_sync #(.STAGES(SYNC_STAGES)) u_sw (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (src_sw),
    .pin_o (sw_sync)
  );

  presel_reg #(.W(REG_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_we),
    .gate_i (manual_mode_en),
    .data_i (cfg_wdata),
    .q_o    (reg_q)
  );

  always_comb begin
    pick = field_pick_e'(sw_sync);
    unique case (pick)
      FIELD_A: active_code = reg_q[FIELD_W-1:0];
      FIELD_B: active_code = reg_q[REG_W-1:FIELD_W];
      default: active_code = reg_q[FIELD_W-1:0];
    endcase
  end

  presel_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (active_code),
    .sel_o  (sel_req),
    .rsvd_o (sel_reserved)
  );

  assign cfg_rdata = reg_q;

  // R4: the field chosen by the synchronized pin drives a stable decode
  assert_field_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sw_sync) && $stable(reg_q) && !sel_reserved) |=> $stable(sel_req));
endmodule

// File: tb/tb_presel_top.sv
module tb_presel_top;
  logic       clk;
  logic       arst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       manual_mode_en;
  logic       src_sw;
  logic [7:0] cfg_rdata;
  logic [6:0] sel_req;
  logic       sel_reserved;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int         due;
    logic [6:0] s;
    logic       f;
    logic [7:0] r;
    string      req;
  } exp_t;
  exp_t sb[$];

  localparam logic [6:0] FR = 7'b0000001;

  presel_top dut (
    .clk            (clk),
    .arst_n         (arst_n),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .manual_mode_en (manual_mode_en),
    .src_sw         (src_sw),
    .cfg_rdata      (cfg_rdata),
    .sel_req        (sel_req),
    .sel_reserved   (sel_reserved)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when due, compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (sel_req !== e.s) begin
        errors++;
        $display("FAIL %s sel_req actual %b expected %b", e.req, sel_req, e.s);
      end
      checks++;
      if (sel_reserved !== e.f) begin
        errors++;
        $display("FAIL %s sel_reserved actual %b expected %b", e.req, sel_reserved, e.f);
      end
      checks++;
      if (cfg_rdata !== e.r) begin
        errors++;
        $display("FAIL %s cfg_rdata actual %h expected %h", e.req, cfg_rdata, e.r);
      end
      checks++;
      if ($countones(sel_req) != 1) begin
        errors++;
        $display("FAIL R8 onehot actual %b expected one bit set", sel_req);
      end
    end
  end

  // driver side: push the expectation for the next edge, then advance
  task automatic step(input logic [6:0] s, input logic f, input logic [7:0] r,
                      input string req);
    exp_t e;
    e.due = cyc + 1;
    e.s = s;
    e.f = f;
    e.r = r;
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // decode rule per R6/R7, written from the requirement
  function automatic logic code_valid(input int c);
    return (c <= 5) || (c == 13);
  endfunction

  function automatic logic [6:0] code_sel(input int c);
    if (c == 13) return 7'b1000000;
    return 7'(1) << c;
  endfunction

  logic [6:0] prev_s;
  logic       prev_f;
  logic [7:0] cur_r;

  initial begin
    arst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    manual_mode_en = 1'b0;
    src_sw = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    step(FR, 1'b0, 8'h00, "R1");

    // R2 gated write of 0x31, low nibble 1 active with pin low (R4, R6)
    manual_mode_en = 1'b1;
    cfg_we = 1'b1;
    cfg_wdata = 8'h31;
    step(FR, 1'b0, 8'h31, "R2");
    cfg_we = 1'b0;
    step(7'b0000010, 1'b0, 8'h31, "R4_R6");

    // R5 pin to high: two edges old, third edge high nibble (ref 3)
    src_sw = 1'b1;
    step(7'b0000010, 1'b0, 8'h31, "R5");
    step(7'b0000010, 1'b0, 8'h31, "R5");
    step(7'b0001000, 1'b0, 8'h31, "R5_R4");

    // R3 write with gate low ignored; R9 read still returns both fields
    manual_mode_en = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = 8'hD5;
    step(7'b0001000, 1'b0, 8'h31, "R3");
    cfg_we = 1'b0;
    step(7'b0001000, 1'b0, 8'h31, "R3_R9");
    step(7'b0001000, 1'b0, 8'h31, "R9");

    // R6/R7 sweep all codes through the high nibble (pin high)
    prev_s = 7'b0001000;
    prev_f = 1'b0;
    cur_r  = 8'h31;
    manual_mode_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      logic [6:0] ns;
      logic       nf;
      cfg_we = 1'b1;
      cfg_wdata = {4'(c), 4'h1};
      step(prev_s, prev_f, cfg_wdata, "R2");
      cur_r = {4'(c), 4'h1};
      cfg_we = 1'b0;
      ns = code_valid(c) ? code_sel(c) : prev_s;
      nf = !code_valid(c);
      step(ns, nf, cur_r, code_valid(c) ? "R6" : "R7");
      prev_s = ns;
      prev_f = nf;
    end

    // R4/R7: back to low field (code 1) clears the flag after sync delay
    src_sw = 1'b0;
    step(prev_s, prev_f, cur_r, "R5");
    step(prev_s, prev_f, cur_r, "R5");
    step(7'b0000010, 1'b0, cur_r, "R4_R7");

    // R7 reserved low nibble 9 holds ref 1; R9 with gate low
    cfg_we = 1'b1;
    cfg_wdata = 8'hF9;
    step(7'b0000010, 1'b0, 8'hF9, "R2");
    cfg_we = 1'b0;
    manual_mode_en = 1'b0;
    step(7'b0000010, 1'b1, 8'hF9, "R7_R9");
    step(7'b0000010, 1'b1, 8'hF9, "R7");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule